// File: doc/BRIEF.md
# Saturating Dual Accumulator Adder

This block holds two 40-bit accumulators, A and B, each formed as 8 guard bits above a 1.31 fractional field. A single 40-bit adder/subtracter serves both. Each cycle it may take one operation (add, subtract, load, negate or clear) on the accumulator chosen by `acc_sel_i`, with a sign-extended 40-bit operand supplied by the surrounding datapath. The multiplier, operand fetch, rounding and shifting stay outside.

Each accumulator has its own saturation enable. A shared mode input picks the clamp limit when saturation is on: either the full 40-bit range or the 1.31 range. An overflow flag per accumulator reports guard-bit use and is recomputed on every adder operation. A sticky saturation flag per accumulator records clamps or, when saturation is off, catastrophic sign loss. Both kinds of flag can raise trap requests.

Top module: `sat_acc_adder`

## Requirements
- R1: After reset both accumulators and all six status flags read zero.
- R2: Operation codes are 1 add (acc + operand), 2 subtract (acc − operand), 3 load (operand), 4 negate (0 − acc). The result is written to the accumulator picked by `acc_sel_i` (0 = A, 1 = B) at the next rising clock edge. The other accumulator and its flags do not change. Without a clamp the result wraps modulo 2^40.
- R3: Operation code 5 writes zero to the selected accumulator and leaves every flag unchanged.
- R4: After each adder operation, the target's overflow flag (OA or OB) is set when bits 39..32 of the 40-bit sum are not all equal, or when the sum overflowed bit 39. Otherwise it is cleared.
- R5: With saturation enabled for the target and `sat_mode31_i` = 0, a bit-39 overflow writes 0x7FFFFFFFFF (positive true result) or 0x8000000000 (negative) and sets the target's saturation flag.
- R6: With saturation enabled and `sat_mode31_i` = 1, a true result outside the range −2^31..2^31−1 writes 0x007FFFFFFF or 0xFF80000000 and sets the saturation flag. The target's overflow flag is cleared in this mode.
- R7: With saturation disabled for the target, the sum wraps and a bit-39 overflow sets the saturation flag.
- R8: SA and SB are sticky. `clr_sat_i` clears both at the next edge, except that a saturation event on the target in the same cycle sets that flag.
- R9: `oab_o` is OA OR OB and `sab_o` is SA OR SB.
- R10: `ovf_trap_o` is high while (OA and `ovf_trap_en_a_i`) or (OB and `ovf_trap_en_b_i`). `cat_trap_o` is high while `cat_trap_en_i` and a set SA or SB whose accumulator has saturation disabled.
- R11: Operation codes 0, 6 and 7 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_code_i | input | 3 | Operation code |
| acc_sel_i | input | 1 | Target accumulator, 0 = A, 1 = B |
| operand_i | input | 40 | Sign-extended operand |
| sat_en_a_i | input | 1 | Saturation enable for A |
| sat_en_b_i | input | 1 | Saturation enable for B |
| sat_mode31_i | input | 1 | 1 = clamp to 1.31 range, 0 = clamp to 40-bit range |
| clr_sat_i | input | 1 | Clear sticky saturation flags |
| ovf_trap_en_a_i | input | 1 | Overflow trap enable for A |
| ovf_trap_en_b_i | input | 1 | Overflow trap enable for B |
| cat_trap_en_i | input | 1 | Catastrophic-overflow trap enable |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| oa_o | output | 1 | Guard overflow flag A |
| ob_o | output | 1 | Guard overflow flag B |
| sa_o | output | 1 | Sticky saturation flag A |
| sb_o | output | 1 | Sticky saturation flag B |
| oab_o | output | 1 | OA or OB |
| sab_o | output | 1 | SA or SB |
| ovf_trap_o | output | 1 | Overflow trap request |
| cat_trap_o | output | 1 | Catastrophic trap request |

## Verification
Accumulator values and all four flags are due at the first rising edge after the operation is presented, since there is one register stage. The trap outputs follow the registered flags and the live enables in the same cycle. The bench drives each operation on the falling edge and samples every output shortly after the next rising edge, with the enables still held. Its model steps exactly once per edge, so every output is compared in the cycle it becomes valid. Random operations are mixed with directed runs at the 40-bit and 1.31 limits.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_LOAD = 3'd3,
    OP_NEG  = 3'd4,
    OP_CLR  = 3'd5
  } acc_op_e;

  function automatic logic uses_adder(acc_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_LOAD) || (op == OP_NEG);
  endfunction
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub
  import acc_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] operand_i,
  input  acc_op_e          op_i,
  output logic [ACC_W:0]   ext_o
);
  logic             zero_a, invert_b;
  logic [ACC_W-1:0] a_in, b_src, b_in;

  always_comb begin
    zero_a   = (op_i == OP_LOAD) || (op_i == OP_NEG);
    invert_b = (op_i == OP_SUB)  || (op_i == OP_NEG);
    a_in     = zero_a ? '0 : acc_i;
    b_src    = (op_i == OP_NEG) ? acc_i : operand_i;
    b_in     = invert_b ? ~b_src : b_src;
  end

  // one extra bit keeps the true sign of the exact result
  assign ext_o = {a_in[ACC_W-1], a_in} + {b_in[ACC_W-1], b_in} + (ACC_W+1)'(invert_b);
endmodule

// File: rtl/acc_satlogic.sv
module acc_satlogic #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32
) (
  input  logic [ACC_W:0]   ext_i,
  input  logic             sat_en_i,
  input  logic             mode31_i,
  output logic [ACC_W-1:0] res_o,
  output logic             ovf_flag_o,
  output logic             sat_evt_o
);
  localparam int GUARD_W = ACC_W - FRAC_W;
  localparam logic [ACC_W-1:0] MAX_TOP  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_TOP  = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_FRAC = {{(GUARD_W+1){1'b0}}, {(FRAC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_FRAC = {{(GUARD_W+1){1'b1}}, {(FRAC_W-1){1'b0}}};

  logic [ACC_W-1:0]   sum;
  logic [GUARD_W-1:0] guard;
  logic [GUARD_W+1:0] frac_hi;
  logic               neg, top_ovf, guard_ne, frac_ovf;

  always_comb begin
    sum      = ext_i[ACC_W-1:0];
    neg      = ext_i[ACC_W];
    guard    = sum[ACC_W-1:FRAC_W];
    frac_hi  = ext_i[ACC_W:FRAC_W-1];
    top_ovf  = ext_i[ACC_W] ^ ext_i[ACC_W-1];
    guard_ne = !((&guard) || !(|guard));
    frac_ovf = !((&frac_hi) || !(|frac_hi));

    res_o      = sum;
    ovf_flag_o = guard_ne | top_ovf;
    sat_evt_o  = top_ovf;
    if (sat_en_i && mode31_i) begin
      ovf_flag_o = 1'b0;
      sat_evt_o  = frac_ovf;
      if (frac_ovf) res_o = neg ? MIN_FRAC : MAX_FRAC;
    end else if (sat_en_i && top_ovf) begin
      res_o = neg ? MIN_TOP : MAX_TOP;
    end
  end
endmodule

// File: rtl/acc_lane.sv
module acc_lane #(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             zero_i,
  input  logic [ACC_W-1:0] res_i,
  input  logic             ovf_i,
  input  logic             sat_evt_i,
  input  logic             clr_sat_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             sat_o
);
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q, sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      if (wr_i) begin
        acc_q <= res_i;
        ovf_q <= ovf_i;
      end else if (zero_i) begin
        acc_q <= '0;
      end
      if (wr_i && sat_evt_i) sat_q <= 1'b1;
      else if (clr_sat_i)    sat_q <= 1'b0;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
  assign sat_o = sat_q;

  a_r8_sat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_q && !clr_sat_i) |=> sat_q);
  a_r8_sat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sat_i && !(wr_i && sat_evt_i)) |=> !sat_q);
  a_r8_sat_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sat_evt_i) |=> sat_q);
  a_r3_zero_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i && !wr_i && !clr_sat_i) |=> (acc_q == '0) && $stable(ovf_q) && $stable(sat_q));
endmodule

// File: rtl/sat_acc_adder.sv
module sat_acc_adder
  import acc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_code_i,
  input  logic             acc_sel_i,
  input  logic [ACC_W-1:0] operand_i,
  input  logic             sat_en_a_i,
  input  logic             sat_en_b_i,
  input  logic             sat_mode31_i,
  input  logic             clr_sat_i,
  input  logic             ovf_trap_en_a_i,
  input  logic             ovf_trap_en_b_i,
  input  logic             cat_trap_en_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             oa_o,
  output logic             ob_o,
  output logic             sa_o,
  output logic             sb_o,
  output logic             oab_o,
  output logic             sab_o,
  output logic             ovf_trap_o,
  output logic             cat_trap_o
);
  localparam int NUM_ACC = 2;

  acc_op_e          op;
  logic [ACC_W-1:0] acc_q   [NUM_ACC];
  logic             ovf_q   [NUM_ACC];
  logic             sat_q   [NUM_ACC];
  logic             sat_en  [NUM_ACC];
  logic [ACC_W-1:0] sel_acc, res;
  logic [ACC_W:0]   ext;
  logic             sel_sat_en, ovf_flag, sat_evt, thru;

  assign op         = acc_op_e'(op_code_i);
  assign thru       = uses_adder(op);
  assign sat_en[0]  = sat_en_a_i;
  assign sat_en[1]  = sat_en_b_i;
  assign sel_acc    = acc_q[acc_sel_i];
  assign sel_sat_en = sat_en[acc_sel_i];

  acc_addsub #(.ACC_W(ACC_W)) u_addsub (
    .acc_i     (sel_acc),
    .operand_i (operand_i),
    .op_i      (op),
    .ext_o     (ext)
  );

  acc_satlogic #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_sat (
    .ext_i      (ext),
    .sat_en_i   (sel_sat_en),
    .mode31_i   (sat_mode31_i),
    .res_o      (res),
    .ovf_flag_o (ovf_flag),
    .sat_evt_o  (sat_evt)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_lane
    logic hit;
    assign hit = (acc_sel_i == 1'(g));
    acc_lane #(.ACC_W(ACC_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (hit && thru),
      .zero_i    (hit && (op == OP_CLR)),
      .res_i     (res),
      .ovf_i     (ovf_flag),
      .sat_evt_i (sat_evt),
      .clr_sat_i (clr_sat_i),
      .acc_o     (acc_q[g]),
      .ovf_o     (ovf_q[g]),
      .sat_o     (sat_q[g])
    );
  end

  assign acc_a_o    = acc_q[0];
  assign acc_b_o    = acc_q[1];
  assign oa_o       = ovf_q[0];
  assign ob_o       = ovf_q[1];
  assign sa_o       = sat_q[0];
  assign sb_o       = sat_q[1];
  assign oab_o      = ovf_q[0] | ovf_q[1];
  assign sab_o      = sat_q[0] | sat_q[1];
  assign ovf_trap_o = (ovf_q[0] & ovf_trap_en_a_i) | (ovf_q[1] & ovf_trap_en_b_i);
  assign cat_trap_o = cat_trap_en_i & ((sat_q[0] & ~sat_en_a_i) | (sat_q[1] & ~sat_en_b_i));

  a_r6_no_guard_flag_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thru && !acc_sel_i && sat_en_a_i && sat_mode31_i) |=> !oa_o);
  a_r6_frac_range_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thru && !acc_sel_i && sat_en_a_i && sat_mode31_i)
      |=> ((&acc_a_o[ACC_W-1:FRAC_W-1]) || !(|acc_a_o[ACC_W-1:FRAC_W-1])));
  a_r2_other_b_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_sel_i |=> ($stable(acc_b_o) && $stable(ob_o)));
  a_r2_other_a_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_sel_i |=> ($stable(acc_a_o) && $stable(oa_o)));
  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!thru && op != OP_CLR && !clr_sat_i)
      |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(sab_o) && $stable(oab_o)));
endmodule

// File: tb/sim_sat_acc_adder.sv
module sim_sat_acc_adder;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_code_i = '0;
  logic        acc_sel_i = 1'b0;
  logic [39:0] operand_i = '0;
  logic        sat_en_a_i = 1'b0, sat_en_b_i = 1'b0, sat_mode31_i = 1'b0, clr_sat_i = 1'b0;
  logic        ovf_trap_en_a_i = 1'b0, ovf_trap_en_b_i = 1'b0, cat_trap_en_i = 1'b0;
  logic [39:0] acc_a_o, acc_b_o;
  logic        oa_o, ob_o, sa_o, sb_o, oab_o, sab_o, ovf_trap_o, cat_trap_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [39:0] m_acc [2];
  logic        m_ov  [2];
  logic        m_sat [2];

  always #(CLK_P/2) clk_i = ~clk_i;

  sat_acc_adder u0 (.*);

  function automatic longint sx(input logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  task automatic chk(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "acc_a", acc_a_o, m_acc[0]);
    chk(req, "acc_b", acc_b_o, m_acc[1]);
    chk(req, "flags oa ob sa sb", 40'({oa_o, ob_o, sa_o, sb_o}), 40'({m_ov[0], m_ov[1], m_sat[0], m_sat[1]}));
    chk("R9", "oab sab", 40'({oab_o, sab_o}), 40'({m_ov[0] | m_ov[1], m_sat[0] | m_sat[1]}));
    chk("R10", "traps", 40'({ovf_trap_o, cat_trap_o}),
        40'({(m_ov[0] & ovf_trap_en_a_i) | (m_ov[1] & ovf_trap_en_b_i),
             cat_trap_en_i & ((m_sat[0] & ~sat_en_a_i) | (m_sat[1] & ~sat_en_b_i))}));
  endtask

  // one operation: drive on falling edge, model one edge, sample after rising edge
  task automatic step(input logic [2:0] op, input logic sel, input logic [39:0] opd,
                      input logic sa, input logic sb, input logic m31, input logic clr,
                      input string req);
    longint a, b, r, lim39, lim31;
    logic [63:0] t;
    logic [39:0] nv;
    logic top, f31, guard, en, oflag, ev, thru;
    @(negedge clk_i);
    op_code_i = op; acc_sel_i = sel; operand_i = opd;
    sat_en_a_i = sa; sat_en_b_i = sb; sat_mode31_i = m31; clr_sat_i = clr;
    lim39 = longint'(1) <<< 39;
    lim31 = longint'(1) <<< 31;
    a = sx(m_acc[sel]); b = sx(opd); r = 0;
    thru = (op >= 3'd1) && (op <= 3'd4);
    case (op)
      3'd1: r = a + b;
      3'd2: r = a - b;
      3'd3: r = b;
      3'd4: r = -a;
      default: r = 0;
    endcase
    t = 64'(r);
    top = (r >= lim39) || (r < -lim39);
    f31 = (r >= lim31) || (r < -lim31);
    guard = (t[39:32] != 8'h00) && (t[39:32] != 8'hFF);
    en = sel ? sb : sa;
    nv = t[39:0];
    if (en && m31) begin
      oflag = 1'b0; ev = f31;
      if (f31) nv = (r < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
    end else begin
      oflag = guard | top; ev = top;
      if (en && top) nv = (r < 0) ? 40'h8000000000 : 40'h7FFFFFFFFF;
    end
    @(posedge clk_i);
    for (int k = 0; k < 2; k++) begin
      if (thru && k == int'(sel) && ev) m_sat[k] = 1'b1;
      else if (clr)                     m_sat[k] = 1'b0;
    end
    if (thru) begin
      m_acc[sel] = nv;
      m_ov[sel]  = oflag;
    end else if (op == 3'd5) begin
      m_acc[sel] = '0;
    end
    #1;
    compare(req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] opd;
    logic [31:0] r0;
    for (int k = 0; k < 2; k++) begin m_acc[k] = '0; m_ov[k] = 1'b0; m_sat[k] = 1'b0; end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #1; compare("R1");
    @(negedge clk_i); rst_ni = 1'b1;
    #1; compare("R1");

    // R2 arithmetic on both lanes
    step(3'd3, 0, 40'h0000001234, 0, 0, 0, 0, "R2");
    step(3'd1, 0, 40'h0000000010, 0, 0, 0, 0, "R2");
    step(3'd2, 0, 40'h0000000005, 0, 0, 0, 0, "R2");
    step(3'd4, 0, 40'h0, 0, 0, 0, 0, "R2");
    step(3'd3, 1, 40'hFFFFFFF000, 0, 0, 0, 0, "R2");
    step(3'd2, 1, 40'hFFFFFFFFFF, 0, 0, 0, 0, "R2");
    // R11 idle codes
    step(3'd0, 0, 40'h123456789A, 0, 0, 0, 0, "R11");
    step(3'd6, 1, 40'h7FFFFFFFFF, 0, 0, 0, 0, "R11");
    step(3'd7, 0, 40'h8000000000, 0, 0, 0, 0, "R11");
    // R4 guard bits in use, then back in range
    step(3'd3, 0, 40'h0100000000, 0, 0, 0, 0, "R4");
    step(3'd3, 0, 40'h0000000100, 0, 0, 0, 0, "R4");
    step(3'd3, 1, 40'hFE00000000, 0, 0, 0, 0, "R4");
    // R7 wrap with catastrophic record, trap on
    cat_trap_en_i = 1'b1; ovf_trap_en_b_i = 1'b1;
    step(3'd3, 0, 40'h7FFFFFFFFF, 0, 0, 0, 0, "R7");
    step(3'd1, 0, 40'h0000000001, 0, 0, 0, 0, "R7");
    step(3'd0, 0, 40'h0, 1, 0, 0, 0, "R10");
    // R3 clear keeps flags
    step(3'd5, 0, 40'h0, 0, 0, 0, 0, "R3");
    step(3'd5, 1, 40'h0, 0, 0, 0, 0, "R3");
    // R8 clear of sticky flags, then set wins over clear
    step(3'd0, 0, 40'h0, 0, 0, 0, 1, "R8");
    step(3'd3, 1, 40'h8000000000, 0, 0, 0, 0, "R8");
    step(3'd2, 1, 40'h0000000001, 0, 0, 0, 1, "R8");
    step(3'd0, 1, 40'h0, 0, 0, 0, 0, "R8");
    // R5 40-bit clamp, both directions and negate of most negative
    step(3'd3, 0, 40'h7FFFFFFFFF, 1, 0, 0, 1, "R5");
    step(3'd1, 0, 40'h0000000001, 1, 0, 0, 0, "R5");
    step(3'd3, 0, 40'h8000000000, 1, 0, 0, 0, "R5");
    step(3'd2, 0, 40'h0000000001, 1, 0, 0, 0, "R5");
    step(3'd4, 0, 40'h0, 1, 0, 0, 1, "R5");
    // R6 1.31 clamp, guard flag suppressed
    step(3'd3, 1, 40'h007FFFFFFF, 0, 1, 1, 1, "R6");
    step(3'd1, 1, 40'h0000000001, 0, 1, 1, 0, "R6");
    step(3'd3, 1, 40'hFF80000000, 0, 1, 1, 1, "R6");
    step(3'd2, 1, 40'h0000000001, 0, 1, 1, 0, "R6");
    step(3'd3, 1, 40'h0100000000, 0, 1, 1, 0, "R6");
    step(3'd3, 1, 40'h007FFFFFFF, 0, 1, 1, 1, "R6");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      r0 = $urandom();
      case ($urandom() % 4)
        0: opd = {r0[7:0], $urandom()};
        1: opd = 40'(signed'(r0[11:0]));
        2: case (r0 % 4)
             0: opd = 40'h7FFFFFFFFF;
             1: opd = 40'h8000000000;
             2: opd = 40'h007FFFFFFF;
             default: opd = 40'hFF80000000;
           endcase
        default: opd = 40'(signed'(r0));
      endcase
      ovf_trap_en_a_i = r0[20]; ovf_trap_en_b_i = r0[21]; cat_trap_en_i = r0[22];
      step(3'($urandom() % 8), r0[23], opd, r0[24], r0[25], r0[26], (r0[31:28] == 4'h0), "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule